// File: doc/BRIEF.md
# Extended Address I/O Port

This block drives four bidirectional pads. Each pad can carry one of the upper address lines (pad 0 carries A16, pad 1 A17, pad 2 A18, pad 3 A19). A pad whose address line is not needed serves as general-purpose I/O instead. Software sets up the port through a small register bus. There is a per-pad function-select register, a direction register and an output data register. A read-only pin-level register returns the synchronised pad inputs.

A pad selected for its address function ignores its direction and data bits. It drives the core's upper-address bit in push-pull mode. That override is suspended while the chip is in hold, idle or powerdown. During those states the pad falls back to its I/O setting. The pad outputs and their enables are registered, so they follow a register or state change on the next clock edge. Pull-ups and pad electrical behaviour are outside the block.

Top module: `xport_top`

## Requirements
- R1: While reset is high and after it is released, function-select reads 0x00, direction reads 0x0F, data reads 0x0F, and every pad enable is 0.
- R2: Registers are decoded at these full 16-bit addresses: function-select 16'h1FE1, direction 16'h1FE3, data 16'h1FE5, pin level 16'h1FE7. Bit n of each register belongs to pad n. Writes keep bits 3:0, and reads return bits 7:4 as zero.
- R3: A pad in I/O mode (function bit 0) with direction bit 0 drives its data bit, with its enable at 1.
- R4: A pad in I/O mode with direction bit 1 works as open drain. Data 0 gives output 0 with enable 1. Data 1 gives output 0 with enable 0.
- R5: A pad with function bit 1 drives the upper-address input bit of the same index, with enable 1, whatever its direction and data bits are.
- R6: While hold, idle or powerdown is high, a pad with function bit 1 behaves as R3/R4 dictate from its direction and data bits.
- R7: Pads are independent. Any mix of address-function and I/O pads gives each pad the behaviour of its own bits.
- R8: A write whose address differs from a register address in any bit leaves all registers unchanged. The pin-level register ignores writes. A read of an unmapped address returns 0x00.
- R9: The pin-level register returns the pad input levels through a two-flop synchroniser, in every pad mode.
- R10: Pad outputs are registered. A change to a register, to the upper-address input or to a state input appears on the pads one clock edge later. Read data appears the edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| xaddr | input | 4 | Upper address bits from the core, bit 0 is A16 |
| hold_st | input | 1 | Bus hold state |
| idle_st | input | 1 | Idle state |
| pdown_st | input | 1 | Powerdown state |
| pad_i | input | 4 | Pad input levels |
| pad_o | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |

## Verification
The checker watches every cycle for the per-pad drive rules: push-pull data, open drain, address override and the fallback in low-power or hold states, each against the register values of the cycle before. It also checks that the registers stay frozen after a write that does not decode, and that the pads float while reset is applied. Only the bench scenarios can show the register reset values and read-back. They also cover the masking of upper data bits, rejection of aliased addresses and the latency of the synchroniser to the pin-level read. Those scenarios also exercise mixed pad configurations with concrete values.

// File: rtl/xport_pkg.sv
package xport_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] FSEL_ADDR = 16'h1FE1;
  localparam logic [AW-1:0] DIR_ADDR  = 16'h1FE3;
  localparam logic [AW-1:0] DATA_ADDR = 16'h1FE5;
  localparam logic [AW-1:0] PIN_ADDR  = 16'h1FE7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FSEL,
    SEL_DIR,
    SEL_DATA,
    SEL_PIN
  } reg_sel_e;
endpackage

// File: rtl/xport_decode.sv
module xport_decode
  import xport_pkg::*;
(
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    unique case (addr)
      FSEL_ADDR: sel = SEL_FSEL;
      DIR_ADDR:  sel = SEL_DIR;
      DATA_ADDR: sel = SEL_DATA;
      PIN_ADDR:  sel = SEL_PIN;
      default:   sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/xport_sync.sv
module xport_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xport_regs.sv
module xport_regs
  import xport_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  reg_sel_e      sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic [W-1:0]  pin_lvl,
  output logic [DW-1:0] rdata,
  output logic [W-1:0]  fsel_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  data_q
);
  localparam logic [W-1:0] FSEL_RST = '0;
  localparam logic [W-1:0] DIR_RST  = '1;
  localparam logic [W-1:0] DATA_RST = '1;

  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q <= FSEL_RST;
      dir_q  <= DIR_RST;
      data_q <= DATA_RST;
    end else if (wr) begin
      case (sel)
        SEL_FSEL: fsel_q <= wdata[W-1:0];
        SEL_DIR:  dir_q  <= wdata[W-1:0];
        SEL_DATA: data_q <= wdata[W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_FSEL: rd_mux[W-1:0] = fsel_q;
      SEL_DIR:  rd_mux[W-1:0] = dir_q;
      SEL_DATA: rd_mux[W-1:0] = data_q;
      SEL_PIN:  rd_mux[W-1:0] = pin_lvl;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/xport_pinctl.sv
module xport_pinctl #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inact,
  input  logic [W-1:0] fsel,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] data,
  input  logic [W-1:0] xaddr,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic addr_mode;
    logic o_q, oe_q;

    assign addr_mode = fsel[i] & ~inact;

    always_ff @(posedge clk) begin
      if (rst) begin
        o_q  <= 1'b0;
        oe_q <= 1'b0;
      end else if (addr_mode) begin
        o_q  <= xaddr[i];
        oe_q <= 1'b1;
      end else if (!dir[i]) begin
        o_q  <= data[i];
        oe_q <= 1'b1;
      end else begin
        o_q  <= 1'b0;
        oe_q <= ~data[i];
      end
    end

    assign pad_o[i]  = o_q;
    assign pad_oe[i] = oe_q;
  end
endmodule

// File: rtl/xport_top.sv
module xport_top
  import xport_pkg::*;
#(
  parameter int unsigned W         = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_rd,
  output logic [7:0]    bus_rdata,
  input  logic [W-1:0]  xaddr,
  input  logic          hold_st,
  input  logic          idle_st,
  input  logic          pdown_st,
  input  logic [W-1:0]  pad_i,
  output logic [W-1:0]  pad_o,
  output logic [W-1:0]  pad_oe
);
  reg_sel_e     sel;
  logic [W-1:0] fsel_q, dir_q, data_q, pin_lvl;
  logic         inact;

  assign inact = hold_st | idle_st | pdown_st;

  xport_decode u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  xport_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_i),
    .q   (pin_lvl)
  );

  xport_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .rd      (bus_rd),
    .pin_lvl (pin_lvl),
    .rdata   (bus_rdata),
    .fsel_q  (fsel_q),
    .dir_q   (dir_q),
    .data_q  (data_q)
  );

  xport_pinctl #(.W(W)) u_pins (
    .clk    (clk),
    .rst    (rst),
    .inact  (inact),
    .fsel   (fsel_q),
    .dir    (dir_q),
    .data   (data_q),
    .xaddr  (xaddr),
    .pad_o  (pad_o),
    .pad_oe (pad_oe)
  );
endmodule

// File: rtl/xport_chk.sv
module xport_chk
  import xport_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [15:0]   bus_addr,
  input logic          bus_wr,
  input logic [W-1:0]  xaddr,
  input logic          hold_st,
  input logic          idle_st,
  input logic          pdown_st,
  input logic [W-1:0]  fsel_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  data_q,
  input logic [W-1:0]  pad_o,
  input logic [W-1:0]  pad_oe
);
  logic         inact_c;
  logic [W-1:0] am, pp, od;
  logic         unmapped_wr;
  logic         rst_seen = 1'b0;

  assign inact_c = hold_st | idle_st | pdown_st;
  assign am = fsel_q & {W{~inact_c}};
  assign pp = ~am & ~dir_q;
  assign od = ~am & dir_q;
  assign unmapped_wr = bus_wr && (bus_addr != FSEL_ADDR) &&
                       (bus_addr != DIR_ADDR) && (bus_addr != DATA_ADDR);

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      a_r1_float_in_reset: assert (pad_oe == '0);
    end
  end

  a_r3_push_pull: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((pad_oe & $past(pp)) == $past(pp)) &&
              (((pad_o ^ $past(data_q)) & $past(pp)) == '0)));

  a_r4_open_drain: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((pad_o & $past(od)) == '0) &&
              (((pad_oe ^ ~$past(data_q)) & $past(od)) == '0)));

  a_r5_addr_drive: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((pad_oe & $past(am)) == $past(am)) &&
              (((pad_o ^ $past(xaddr)) & $past(am)) == '0)));

  a_r6_fallback: assert property (@(posedge clk) disable iff (rst)
    (inact_c && fsel_q != '0) |=>
      ((pad_oe & $past(fsel_q & dir_q & data_q)) == '0));

  a_r8_no_alias_write: assert property (@(posedge clk) disable iff (rst)
    unmapped_wr |=> ($stable(fsel_q) && $stable(dir_q) && $stable(data_q)));
endmodule

bind xport_top xport_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .xaddr    (xaddr),
  .hold_st  (hold_st),
  .idle_st  (idle_st),
  .pdown_st (pdown_st),
  .fsel_q   (fsel_q),
  .dir_q    (dir_q),
  .data_q   (data_q),
  .pad_o    (pad_o),
  .pad_oe   (pad_oe)
);

// File: tb/tb_xport_top.sv
module tb_xport_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_rdata;
  logic [W-1:0] xaddr = '0;
  logic         hold_st = 1'b0, idle_st = 1'b0, pdown_st = 1'b0;
  logic [W-1:0] pad_i = '0;
  logic [W-1:0] pad_o, pad_oe;

  always #5 clk = ~clk;

  xport_top dut (.*);

  typedef struct {
    bit          is_rd;
    logic [7:0]  val;
    logic [W-1:0] o;
    logic [W-1:0] oe;
    string       req;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (it.is_rd) begin
        if (bus_rdata !== it.val) begin
          bad++;
          $display("FAIL %s: rdata actual=%h expected=%h", it.req, bus_rdata, it.val);
        end
      end else if (pad_o !== it.o || pad_oe !== it.oe) begin
        bad++;
        $display("FAIL %s: o/oe actual=%b/%b expected=%b/%b",
                 it.req, pad_o, pad_oe, it.o, it.oe);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
    item_t it;
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    it.is_rd = 1'b1; it.val = exp; it.o = '0; it.oe = '0; it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  // pads reflect registers one edge after the last change
  task automatic pin_chk(input logic [W-1:0] o, input logic [W-1:0] oe, input string req);
    item_t it;
    tick();
    it.is_rd = 1'b0; it.val = '0; it.o = o; it.oe = oe; it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) tick();
    pin_chk(4'b0000, 4'b0000, "R1 pads float in reset");
    rst = 1'b0;
    tick();
    rd_chk(16'h1FE1, 8'h00, "R1 fsel reset");
    rd_chk(16'h1FE3, 8'h0F, "R1 dir reset");
    rd_chk(16'h1FE5, 8'h0F, "R1 data reset");
    pin_chk(4'b0000, 4'b0000, "R1 pads float after reset");

    // R3 push-pull
    wr(16'h1FE5, 8'h0A);
    wr(16'h1FE3, 8'h00);
    pin_chk(4'hA, 4'hF, "R3 push-pull drive");

    // R4 open drain
    wr(16'h1FE3, 8'h0F);
    wr(16'h1FE5, 8'h05);
    pin_chk(4'h0, 4'hA, "R4 open drain");

    // R5 address function overrides dir/data
    wr(16'h1FE5, 8'h0F);
    xaddr = 4'h9;
    wr(16'h1FE1, 8'h0F);
    pin_chk(4'h9, 4'hF, "R5 address drive");
    xaddr = 4'h6;
    pin_chk(4'h6, 4'hF, "R10 xaddr follows one edge later");

    // R6 fallback in each inactive state
    hold_st = 1'b1;
    pin_chk(4'h0, 4'h0, "R6 hold fallback");
    hold_st = 1'b0; idle_st = 1'b1;
    pin_chk(4'h0, 4'h0, "R6 idle fallback");
    idle_st = 1'b0; pdown_st = 1'b1;
    pin_chk(4'h0, 4'h0, "R6 powerdown fallback");
    pdown_st = 1'b0;
    pin_chk(4'h6, 4'hF, "R5 address drive resumes");

    // R7 mixed
    xaddr = 4'hF;
    wr(16'h1FE1, 8'h05);
    wr(16'h1FE3, 8'h0C);
    wr(16'h1FE5, 8'h0A);
    pin_chk(4'b0111, 4'b0111, "R7 mixed pads");

    // R8 aliases and unmapped
    wr(16'h00E3, 8'h00);
    wr(16'h3FE3, 8'h00);
    wr(16'h1FE7, 8'h00);
    rd_chk(16'h1FE3, 8'h0C, "R8 alias writes ignored");
    pin_chk(4'b0111, 4'b0111, "R8 pads unchanged after alias writes");
    rd_chk(16'h1FE0, 8'h00, "R8 unmapped read");

    // R2 upper data bits masked
    wr(16'h1FE3, 8'hF3);
    rd_chk(16'h1FE3, 8'h03, "R2 upper bits read zero");

    // R9 pin level with address pins active
    pad_i = 4'b1011;
    tick(); tick();
    rd_chk(16'h1FE7, 8'h0B, "R9 pin level after sync");
    pad_i = 4'b0100;
    tick();
    rd_chk(16'h1FE7, 8'h0B, "R9 sync latency holds old level");
    rd_chk(16'h1FE7, 8'h04, "R9 new level after two flops");
    rd_chk(16'h1FE1, 8'h05, "R2 fsel read back");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule